// File: doc/BRIEF.md
# Dual Serial Port Interrupt Controller

This block is the register and interrupt front end of a two-channel serial port pair: channel A (console) and channel B (auxiliary). A host reaches it through a simple single-cycle register port. Each channel has a status register, a command register and a holding register. Both channels share one register whose write side loads the interrupt mask and whose read side returns the interrupt status. The block drives one interrupt line.

Received characters come in as per-channel strobes with a byte. Each channel keeps them in a one-byte receive buffer with a full flag. When the host writes a holding register, the block emits that byte on the channel's transmit strobe. A periodic tick input drives a small divider. Every second tick (the divider length is a parameter) the divider re-asserts both transmit-ready interrupt bits, so that a software transmit loop waiting on interrupts keeps moving. Baud generation and serialisation sit outside this block. The counter/timer and output-port registers also sit outside, so their offsets behave as unmapped.

Top module: `duo_serial_irq`

## Requirements
- R1: A status register read (channel A at 0x40C, channel B at 0x44C) returns bit 0 = that channel's receive-buffer full flag, bit 2 = 1 (transmitter always ready) and all other bits 0. Read data appears on `reg_rdata` in the cycle after the access; `reg_rdata` is 0 in any cycle that follows no read.
- R2: A write to 0x42C loads the interrupt mask from `reg_wdata`. A read of 0x42C returns the interrupt status. Status and mask bits are: bit 0 TX-ready A, bit 1 RX-ready A, bit 4 TX-ready B, bit 5 RX-ready B.
- R3: A receive strobe stores the byte and sets the channel's full flag. It sets the channel's RX-ready status bit and raises `irq` only when the matching mask bit is set.
- R4: The block counts ticks. On every TICK_DIV-th tick (default 2) the count returns to zero. If mask bit 0 or bit 4 is set at that tick, status bits 0 and 4 are set and `irq` is raised.
- R5: A read of channel A's status register drops `irq` on the following cycle unless an interrupt is raised in the same cycle. A read of channel B's status register leaves `irq` unchanged. No other access lowers `irq`.
- R6: A write to either holding register (A at 0x41C, B at 0x45C) pulses that channel's transmit strobe for one cycle with the written byte on the next cycle. It also clears status bit 0 (TX-ready A) for either channel; a TX-ready set in the same cycle takes priority.
- R7: A holding register read returns the stored byte. It clears that channel's full flag and RX-ready status bit, unless a new byte arrives in the same cycle, in which case the arrival wins.
- R8: A command register write (A at 0x414, B at 0x454) with bit 3 set pulses that channel's flush output for one cycle on the next cycle. A command write with bit 3 clear produces no pulse.
- R9: Reads of any other offset return 0. Writes to any other offset change no output and no register contents.
- R10: Out of reset, `irq`, the strobes, the flush outputs and `reg_rdata` are 0, and the status, mask, tick count and full flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_en | input | 1 | Register access valid this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the read |
| rx_stb_a | input | 1 | Channel A byte arrival strobe |
| rx_data_a | input | DATA_W | Channel A arriving byte |
| rx_stb_b | input | 1 | Channel B byte arrival strobe |
| rx_data_b | input | DATA_W | Channel B arriving byte |
| tick | input | 1 | Periodic tick for transmit-ready re-assertion |
| irq | output | 1 | Interrupt request |
| tx_stb_a | output | 1 | Channel A transmit byte strobe |
| tx_data_a | output | DATA_W | Channel A transmit byte |
| tx_stb_b | output | 1 | Channel B transmit byte strobe |
| tx_data_b | output | DATA_W | Channel B transmit byte |
| flush_a | output | 1 | Channel A flush request pulse |
| flush_b | output | 1 | Channel B flush request pulse |

## Verification
Every result in this block passes through exactly one register. Read data, transmit strobes, flush pulses and `irq` changes therefore appear in the cycle after the access, strobe or tick that caused them. The receive flags and status bits, which are only visible through later reads, change at that same edge. The bench drives each stimulus half a cycle before a rising edge and samples at the next falling edge. It compares `irq`, `reg_rdata`, both transmit strobes with their bytes, and both flush outputs against its own model on every cycle. Directed checks read registers back through the port one cycle later.

// File: rtl/duo_serial_pkg.sv
package duo_serial_pkg;
  localparam int NLANE = 2;
  localparam logic [11:0] OFF_STAT    = 12'h40C;
  localparam logic [11:0] OFF_CMD     = 12'h414;
  localparam logic [11:0] OFF_HOLD    = 12'h41C;
  localparam logic [11:0] OFF_IRQREG  = 12'h42C;
  localparam logic [11:0] LANE_STRIDE = 12'h040;

  localparam int ST_RX     = 0;
  localparam int ST_TX     = 2;
  localparam int CMD_FLUSH = 3;

  localparam int IS_TXA = 0;
  localparam int IS_RXA = 1;
  localparam int IS_TXB = 4;
  localparam int IS_RXB = 5;

  function automatic logic [11:0] lane_addr(logic [11:0] base, int lane);
    return base + 12'(lane) * LANE_STRIDE;
  endfunction

  function automatic logic [7:0] status_byte(logic full);
    logic [7:0] b;
    b = '0;
    b[ST_RX] = full;
    b[ST_TX] = 1'b1;
    return b;
  endfunction
endpackage

// File: rtl/serial_lane.sv
module serial_lane
  import duo_serial_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_stb,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              hold_rd,
  input  logic              hold_wr,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rx_full,
  output logic [DATA_W-1:0] rx_buf,
  output logic              tx_stb,
  output logic [DATA_W-1:0] tx_data,
  output logic              flush
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_buf  <= '0;
      tx_stb  <= 1'b0;
      tx_data <= '0;
      flush   <= 1'b0;
    end else begin
      if (rx_stb) begin
        rx_full <= 1'b1;
        rx_buf  <= rx_data;
      end else if (hold_rd) begin
        rx_full <= 1'b0;
      end
      tx_stb <= hold_wr;
      if (hold_wr) tx_data <= wdata;
      flush <= cmd_wr && wdata[CMD_FLUSH];
    end
  end

  // R8
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(cmd_wr && wdata[CMD_FLUSH]));
  // R7
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rd && !rx_stb) |=> !rx_full);
  // R6
  tx_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_wr |=> (tx_stb && tx_data == $past(wdata)));
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import duo_serial_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NLANE-1:0]  arrive,
  input  logic [NLANE-1:0]  hold_rd,
  input  logic              hold_wr_any,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stat_a_rd,
  output logic [DATA_W-1:0] isr,
  output logic [DATA_W-1:0] imr,
  output logic              irq
);
  localparam int CW = $clog2(TICK_DIV + 1);

  logic [CW-1:0]     tcnt;
  logic              tick_fire;
  logic [DATA_W-1:0] set_bits, clr_bits;

  assign tick_fire = tick && (tcnt == CW'(TICK_DIV - 1));

  always_comb begin
    set_bits = '0;
    set_bits[IS_RXA] = arrive[0] && imr[IS_RXA];
    set_bits[IS_RXB] = arrive[1] && imr[IS_RXB];
    if (tick_fire && (imr[IS_TXA] || imr[IS_TXB])) begin
      set_bits[IS_TXA] = 1'b1;
      set_bits[IS_TXB] = 1'b1;
    end
    clr_bits = '0;
    clr_bits[IS_TXA] = hold_wr_any;
    clr_bits[IS_RXA] = hold_rd[0];
    clr_bits[IS_RXB] = hold_rd[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt <= '0;
      isr  <= '0;
      imr  <= '0;
      irq  <= 1'b0;
    end else begin
      if (tick) tcnt <= tick_fire ? '0 : tcnt + 1'b1;
      isr <= (isr & ~clr_bits) | set_bits;
      if (mask_wr) imr <= wdata;
      if (set_bits != '0) irq <= 1'b1;
      else if (stat_a_rd) irq <= 1'b0;
    end
  end

  // R4
  tick_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < CW'(TICK_DIV));
  // R5
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_a_rd && set_bits == '0) |=> !irq);
  // R3
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_bits != '0));
  // R3
  rx_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isr[IS_RXA]) |-> $past(imr[IS_RXA] && arrive[0]));
endmodule

// File: rtl/duo_serial_irq.sv
module duo_serial_irq
  import duo_serial_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 8,
  parameter int TICK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              rx_stb_a,
  input  logic [DATA_W-1:0] rx_data_a,
  input  logic              rx_stb_b,
  input  logic [DATA_W-1:0] rx_data_b,
  input  logic              tick,
  output logic              irq,
  output logic              tx_stb_a,
  output logic [DATA_W-1:0] tx_data_a,
  output logic              tx_stb_b,
  output logic [DATA_W-1:0] tx_data_b,
  output logic              flush_a,
  output logic              flush_b
);
  logic [NLANE-1:0]             stat_hit, cmd_hit, hold_hit;
  logic [NLANE-1:0]             lane_rx_stb, lane_full, lane_tx_stb, lane_flush;
  logic [NLANE-1:0][DATA_W-1:0] lane_rx_data, lane_buf, lane_tx_data;
  logic [NLANE-1:0]             hold_rd, hold_wr, cmd_wr;
  logic                         irq_hit, mask_wr, rd_cyc;
  logic [DATA_W-1:0]            isr, imr, rd_next;

  assign lane_rx_stb  = {rx_stb_b, rx_stb_a};
  assign lane_rx_data = {rx_data_b, rx_data_a};
  assign irq_hit = reg_en && (reg_addr == ADDR_W'(OFF_IRQREG));
  assign mask_wr = irq_hit && reg_wr;
  assign rd_cyc  = reg_en && !reg_wr;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign stat_hit[i] = reg_en && (reg_addr == ADDR_W'(lane_addr(OFF_STAT, i)));
    assign cmd_hit[i]  = reg_en && (reg_addr == ADDR_W'(lane_addr(OFF_CMD, i)));
    assign hold_hit[i] = reg_en && (reg_addr == ADDR_W'(lane_addr(OFF_HOLD, i)));
    assign hold_rd[i]  = hold_hit[i] && !reg_wr;
    assign hold_wr[i]  = hold_hit[i] && reg_wr;
    assign cmd_wr[i]   = cmd_hit[i] && reg_wr;

    serial_lane #(.DATA_W(DATA_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .rx_stb(lane_rx_stb[i]), .rx_data(lane_rx_data[i]),
      .hold_rd(hold_rd[i]), .hold_wr(hold_wr[i]), .cmd_wr(cmd_wr[i]),
      .wdata(reg_wdata),
      .rx_full(lane_full[i]), .rx_buf(lane_buf[i]),
      .tx_stb(lane_tx_stb[i]), .tx_data(lane_tx_data[i]),
      .flush(lane_flush[i])
    );
  end

  irq_hub #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) u_hub (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .arrive(lane_rx_stb), .hold_rd(hold_rd),
    .hold_wr_any(|hold_wr), .mask_wr(mask_wr), .wdata(reg_wdata),
    .stat_a_rd(stat_hit[0] && !reg_wr),
    .isr(isr), .imr(imr), .irq(irq)
  );

  always_comb begin
    rd_next = '0;
    if (rd_cyc) begin
      if (irq_hit) rd_next = isr;
      for (int i = 0; i < NLANE; i++) begin
        if (stat_hit[i]) rd_next = DATA_W'(status_byte(lane_full[i]));
        if (hold_hit[i]) rd_next = lane_buf[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else        reg_rdata <= rd_next;
  end

  assign tx_stb_a  = lane_tx_stb[0];
  assign tx_stb_b  = lane_tx_stb[1];
  assign tx_data_a = lane_tx_data[0];
  assign tx_data_b = lane_tx_data[1];
  assign flush_a   = lane_flush[0];
  assign flush_b   = lane_flush[1];

  // R1
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cyc |=> reg_rdata == '0);
  // R1
  stat_tx_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && |stat_hit) |=> reg_rdata[ST_TX]);
  // R9
  unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && !irq_hit && stat_hit == '0 && hold_hit == '0) |=> reg_rdata == '0);
endmodule

// File: tb/duo_serial_irq_bench.sv
`timescale 1ns/1ps
module duo_serial_irq_bench;
  localparam int TICK = 2;
  logic clk = 0, rst_n = 0;
  logic reg_en = 0, reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic rx_stb_a = 0, rx_stb_b = 0, tick = 0;
  logic [7:0] rx_data_a = 0, rx_data_b = 0;
  logic irq, tx_stb_a, tx_stb_b, flush_a, flush_b;
  logic [7:0] tx_data_a, tx_data_b;

  duo_serial_irq #(.ADDR_W(12), .DATA_W(8), .TICK_DIV(TICK)) u_duo_serial_irq (
    .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_stb_a(rx_stb_a), .rx_data_a(rx_data_a), .rx_stb_b(rx_stb_b),
    .rx_data_b(rx_data_b), .tick(tick), .irq(irq),
    .tx_stb_a(tx_stb_a), .tx_data_a(tx_data_a), .tx_stb_b(tx_stb_b),
    .tx_data_b(tx_data_b), .flush_a(flush_a), .flush_b(flush_b));

  always #4 clk = ~clk;

  int vectors = 0, errors = 0;
  int m_isr, m_imr, m_irq, m_tc, m_rd;
  int m_full[2], m_buf[2], m_txs[2], m_txb[2], m_fl[2];

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_isr = 0; m_imr = 0; m_irq = 0; m_tc = 0; m_rd = 0;
    for (int i = 0; i < 2; i++) begin
      m_full[i] = 0; m_buf[i] = 0; m_txs[i] = 0; m_txb[i] = 0; m_fl[i] = 0;
    end
  endtask

  // One clock: predict from current inputs, advance, compare at negedge.
  task automatic cyc();
    int a, rd, wr, setb, clr, n_isr, n_irq, n_rd, chn;
    bit is_stat, is_cmd, is_hold;
    a = reg_addr; rd = reg_en && !reg_wr; wr = reg_en && reg_wr;
    chn = (a >= 'h440) ? 1 : 0;
    is_stat = (a == 'h40C || a == 'h44C);
    is_cmd  = (a == 'h414 || a == 'h454);
    is_hold = (a == 'h41C || a == 'h45C);
    n_rd = 0;
    if (rd) begin
      if (is_stat) n_rd = 4 + m_full[chn];
      else if (is_hold) n_rd = m_buf[chn];
      else if (a == 'h42C) n_rd = m_isr;
    end
    setb = 0; clr = 0;
    if (rx_stb_a && (m_imr & 'h02) != 0) setb |= 'h02;
    if (rx_stb_b && (m_imr & 'h20) != 0) setb |= 'h20;
    if (tick) begin
      m_tc++;
      if (m_tc == TICK) begin
        m_tc = 0;
        if ((m_imr & 'h11) != 0) setb |= 'h11;
      end
    end
    if (wr && is_hold) clr |= 'h01;
    if (rd && a == 'h41C) clr |= 'h02;
    if (rd && a == 'h45C) clr |= 'h20;
    n_isr = (m_isr & ~clr & 'hFF) | setb;
    n_irq = (setb != 0) ? 1 : ((rd && a == 'h40C) ? 0 : m_irq);
    if (wr && a == 'h42C) m_imr = reg_wdata;
    for (int i = 0; i < 2; i++) begin
      bit stb;
      stb = (i == 0) ? rx_stb_a : rx_stb_b;
      m_txs[i] = wr && is_hold && chn == i;
      if (m_txs[i]) m_txb[i] = reg_wdata;
      m_fl[i] = wr && is_cmd && chn == i && reg_wdata[3];
      if (stb) begin
        m_full[i] = 1; m_buf[i] = (i == 0) ? rx_data_a : rx_data_b;
      end else if (rd && is_hold && chn == i) m_full[i] = 0;
    end
    m_isr = n_isr; m_irq = n_irq; m_rd = n_rd;
    @(posedge clk);
    @(negedge clk);
    chk("R5 irq line", irq, m_irq);
    chk("R1 read data", reg_rdata, m_rd);
    chk("R6 tx strobe A", tx_stb_a, m_txs[0]);
    chk("R6 tx strobe B", tx_stb_b, m_txs[1]);
    if (m_txs[0]) chk("R6 tx byte A", tx_data_a, m_txb[0]);
    if (m_txs[1]) chk("R6 tx byte B", tx_data_b, m_txb[1]);
    chk("R8 flush A", flush_a, m_fl[0]);
    chk("R8 flush B", flush_b, m_fl[1]);
  endtask

  task automatic idle();
    reg_en = 0; reg_wr = 0; rx_stb_a = 0; rx_stb_b = 0; tick = 0;
  endtask

  task automatic wr_reg(int a, int d);
    reg_en = 1; reg_wr = 1; reg_addr = 12'(a); reg_wdata = 8'(d);
    cyc(); idle();
  endtask

  task automatic rd_reg(int a, int exp, string tag);
    reg_en = 1; reg_wr = 0; reg_addr = 12'(a);
    cyc(); idle();
    chk(tag, reg_rdata, exp);
  endtask

  task automatic do_tick();
    tick = 1; cyc(); idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 irq after reset", irq, 0);
    chk("R10 rdata after reset", reg_rdata, 0);
    chk("R10 strobes after reset", {tx_stb_a, tx_stb_b, flush_a, flush_b}, 0);
    rst_n = 1;
    cyc();
    rd_reg('h42C, 'h00, "R10 status empty");
    rd_reg('h40C, 'h04, "R1 status A idle");
    // R3 arrival without mask
    rx_stb_a = 1; rx_data_a = 8'hA7; cyc(); idle();
    chk("R3 no irq when masked", irq, 0);
    rd_reg('h40C, 'h05, "R1 status A full");
    rd_reg('h42C, 'h00, "R3 no status bit when masked");
    rd_reg('h41C, 'hA7, "R7 holding A byte");
    rd_reg('h40C, 'h04, "R7 flag cleared");
    // R2 mask, R3 arrival on B
    wr_reg('h42C, 'h22);
    rx_stb_b = 1; rx_data_b = 8'h3C; cyc(); idle();
    chk("R3 irq raised for B", irq, 1);
    rd_reg('h42C, 'h20, "R2 status RX B");
    rd_reg('h44C, 'h05, "R5 status B read");
    chk("R5 status B keeps irq", irq, 1);
    rd_reg('h40C, 'h04, "R5 status A read");
    chk("R5 status A drops irq", irq, 0);
    rd_reg('h45C, 'h3C, "R7 holding B byte");
    rd_reg('h42C, 'h00, "R7 RX B bit cleared");
    // R4 tick divider
    wr_reg('h42C, 'h01);
    do_tick();
    chk("R4 first tick no irq", irq, 0);
    do_tick();
    chk("R4 second tick irq", irq, 1);
    rd_reg('h42C, 'h11, "R4 both TX bits");
    // R6 holding write on B clears TX-ready A
    wr_reg('h45C, 'h5A);
    rd_reg('h42C, 'h10, "R6 TX A cleared by B write");
    wr_reg('h41C, 'hC3);
    // R8 flush
    wr_reg('h414, 'h08);
    wr_reg('h454, 'h07);
    // R9 unmapped offsets
    wr_reg('h424, 'hFF);
    wr_reg('h234, 'hFF);
    rd_reg('h434, 'h00, "R9 unmapped read");
    rd_reg('h23C, 'h00, "R9 unmapped read 2");
    rd_reg('h42C, 'h10, "R9 status unchanged");
    // R7 arrival wins over holding read
    rx_stb_a = 1; rx_data_a = 8'h11; reg_en = 1; reg_wr = 0; reg_addr = 12'h41C;
    cyc(); idle();
    rd_reg('h40C, 'h05, "R7 arrival wins");
    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      int sel;
      int addrs[10] = '{'h40C, 'h414, 'h41C, 'h42C, 'h44C, 'h454, 'h45C, 'h424, 'h474, 'h294};
      sel = $urandom_range(0, 9);
      reg_en = ($urandom_range(0, 2) != 0);
      reg_wr = $urandom_range(0, 1);
      reg_addr = 12'(addrs[sel]);
      reg_wdata = 8'($urandom);
      rx_stb_a = ($urandom_range(0, 5) == 0); rx_data_a = 8'($urandom);
      rx_stb_b = ($urandom_range(0, 5) == 0); rx_data_b = 8'($urandom);
      tick = ($urandom_range(0, 3) == 0);
      cyc();
    end
    idle();
    cyc();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule